// File: doc/BRIEF.md
# Rotate-and-Mask Barrel Shifter

This block is a combinational 32-bit shifter. It takes an operand, a 5-bit shift amount, a direction bit and a 2-bit operation select. It returns the shifted word, a flag that marks an all-zero result, and a flag that marks overflow on left shifts. It covers logical shifts, arithmetic right shift and rotation in both directions. All of these run through one right-rotate network. A generated keep-mask and a sign-fill term then select the bits of the rotated word, so the block has no separate shifter for each operation.

A left shift does not get its own network. The amount is inverted bitwise (ones' complement), the operand is rotated right by that value, and the answer is read from the upper 32 bits of a 33-bit extended rotation. Reading one bit higher makes up for the missing +1 of the two's complement. The mask is built once as a thermometer code. Its mirror image, which costs only wiring, serves as the keep-mask for the other direction. The two flags come from the rotated word and the mask, not from the final result, so they add no logic depth after the result is formed.

The block has no clock and no state. It fits a single-cycle execute stage where the result and flags are used in the same cycle as the inputs.

Top module: `rot_mask_shifter`

## Requirements
- R1: Logical right (select 00, direction 0) by n gives the operand shifted toward bit 0 by n places, with zeros entering at bit 31.
- R2: Arithmetic right (select 01, direction 0) by n gives the same bits as R1 in positions 31-n down to 0, and copies operand bit 31 into the top n positions.
- R3: A left shift with select 00 or 01 gives the operand shifted toward bit 31 by n places, with zeros entering at bit 0. Selects 00 and 01 give identical outputs for left shifts.
- R4: Rotate (select 10) by n moves every bit of the operand by n places, toward bit 0 when the direction is 0 and toward bit 31 when it is 1, wrapping around the word with no bit lost. The number of set bits is preserved.
- R5: A shift amount of 0 returns the operand unchanged for every select and direction, with the overflow flag at 0.
- R6: The zero flag is 1 exactly when the 32-bit result is all zeros.
- R7: The overflow flag is 1 only for a left shift with select 00, 01 or 11. It is 1 when at least one of the n bits shifted out of the top differs from bit 31 of the result. It is 0 for all right shifts and all rotates.
- R8: Select value 11 behaves exactly like select 00 (logical) in both directions.
- R9: Outputs depend only on the present inputs. A change of inputs shows on all three outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opndIn | input | 32 | Operand to be shifted or rotated |
| shiftAmt | input | 5 | Shift or rotate distance, 0 to 31 |
| goLeft | input | 1 | 1 moves bits toward the MSB, 0 toward the LSB |
| opSel | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| resultOut | output | 32 | Shifted or rotated word |
| zeroFlag | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Left shift lost a bit that differs from the new sign bit |

## Verification
The bench sweeps every shift amount in both directions for each select value, and then applies random operands. The aim is the boundary amounts 0, 1 and 31. A wrong one-bit correction on the inverted amount would give left results shifted by one place too many or too few. An off-by-one mask would leave one stale bit behind, or wipe one good bit, at the edge between the kept and the filled region. The sign-fill case uses negative operands at amount 31, where a fill mask of the wrong size shows at once. The overflow checks use patterns such as 0x40000000 shifted left by 1 and 0xC0000000 shifted left by 1. A flag taken from the wrong window, or left enabled for rotates, flips on exactly these patterns.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    OP_LOGIC  = 2'b00,
    OP_ARITH  = 2'b01,
    OP_ROTATE = 2'b10,
    OP_SPARE  = 2'b11
  } shiftOp_e;

  // strobes from control to datapath; amount width fixed by the 32-bit default
  typedef struct packed {
    logic [4:0] rotAmt;     // effective right-rotate distance
    logic       takeHigh;   // read result from the upper window (left shifts)
    logic       keepAll;    // rotate: ignore mask
    logic       signFill;   // arithmetic right with negative operand
    logic       ovfEnable;  // left non-rotate: overflow may be reported
  } shiftStrobes_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             goLeft,
  input  logic [1:0]       opSel,
  input  logic             signBit,
  output shiftStrobes_t    strobes
);

  shiftOp_e opKind;
  logic     isRotate;
  logic     isArith;

  always_comb begin
    opKind   = shiftOp_e'(opSel);
    isRotate = (opKind == OP_ROTATE);
    isArith  = (opKind == OP_ARITH);
  end

  always_comb begin
    // ones' complement of the amount for left; datapath adds the +1 by window
    strobes.rotAmt    = shiftAmt ^ {AMT_W{goLeft}};
    strobes.takeHigh  = goLeft;
    strobes.keepAll   = isRotate;
    strobes.signFill  = !goLeft && isArith && signBit;
    strobes.ovfEnable = goLeft && !isRotate;
  end

  // R7: overflow never enabled for right shifts
  always_comb begin
    a_r7_right_no_ovf_enable: assert (goLeft || !strobes.ovfEnable)
      else $error("overflow enabled on right shift");
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int EXT_W = WIDTH + 1
) (
  input  logic [WIDTH-1:0] opnd,
  input  shiftStrobes_t    strobes,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  // ---------------- right-rotate network (log stages) ----------------
  logic [WIDTH-1:0] stage [0:AMT_W];
  assign stage[0] = opnd;

  for (genvar k = 0; k < AMT_W; k++) begin : g_rot
    localparam int SH = 1 << k;
    assign stage[k+1] = strobes.rotAmt[k]
                        ? {stage[k][SH-1:0], stage[k][WIDTH-1:SH]}
                        : stage[k];
  end

  // 33-bit extended rotation: top bit repeats bit 0 of the rotated word
  logic [EXT_W-1:0] win;
  assign win = {stage[AMT_W][0], stage[AMT_W]};

  // ---------------- mask: greater-than thermometer, then mirrored -------
  logic [EXT_W-1:0] thermo;
  logic [EXT_W-1:0] msk;

  for (genvar t = 0; t < EXT_W; t++) begin : g_thermo
    assign thermo[t] = (t > int'(strobes.rotAmt));
  end

  for (genvar i = 0; i < EXT_W; i++) begin : g_mirror
    assign msk[i] = thermo[WIDTH - i];   // wiring only
  end

  // ---------------- selection, keep, fill ----------------
  logic [WIDTH-1:0] selWin;
  logic [WIDTH-1:0] keepMask;
  logic [WIDTH-1:0] fillMask;
  logic [WIDTH-1:0] kept;
  logic [WIDTH-1:0] lostBits;

  always_comb begin
    selWin   = strobes.takeHigh ? win[EXT_W-1:1] : win[WIDTH-1:0];
    if (strobes.keepAll)       keepMask = '1;
    else if (strobes.takeHigh) keepMask = ~msk[EXT_W-1:1];
    else                       keepMask = msk[WIDTH-1:0];
    fillMask = strobes.signFill ? ~msk[WIDTH-1:0] : '0;
    kept     = selWin & keepMask;
    result   = kept | fillMask;
    // flags from rotated word and mask, parallel to the final OR
    zero     = ~|kept & ~|fillMask;
    lostBits = (selWin ^ {WIDTH{win[EXT_W-1]}}) & msk[EXT_W-1:1];
    ovf      = strobes.ovfEnable & |lostBits;
  end

  always_comb begin
    a_r6_zero_flag: assert (zero == (result == '0))
      else $error("zero flag disagrees with result");
    a_r7_no_overflow: assert (strobes.ovfEnable || !ovf)
      else $error("overflow without left shift");
    a_r4_rotate_keeps_ones: assert (!strobes.keepAll ||
                                    ($countones(result) == $countones(opnd)))
      else $error("rotate changed bit count");
    a_r2_sign_fill: assert (!strobes.signFill || result[WIDTH-1])
      else $error("sign fill missing");
  end

endmodule

// File: rtl/rot_mask_shifter.sv
module rot_mask_shifter
  import shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opndIn,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             goLeft,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] resultOut,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  shiftStrobes_t strobes;

  shift_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .shiftAmt (shiftAmt),
    .goLeft   (goLeft),
    .opSel    (opSel),
    .signBit  (opndIn[WIDTH-1]),
    .strobes  (strobes)
  );

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .opnd    (opndIn),
    .strobes (strobes),
    .result  (resultOut),
    .zero    (zeroFlag),
    .ovf     (ovfFlag)
  );

  always_comb begin
    a_r5_zero_amount_identity: assert ((shiftAmt != '0) ||
                                       ((resultOut == opndIn) && !ovfFlag))
      else $error("amount zero altered operand");
  end

endmodule

// File: tb/rot_mask_shifter_bench.sv
module rot_mask_shifter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opndIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic        goLeft = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] resultOut;
  logic        zeroFlag;
  logic        ovfFlag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  rot_mask_shifter u_rot_mask_shifter (
    .opndIn(opndIn), .shiftAmt(shiftAmt), .goLeft(goLeft), .opSel(opSel),
    .resultOut(resultOut), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  function automatic logic [31:0] modelRes(logic [31:0] a, int n, bit left, logic [1:0] op);
    if (op == 2'b10)
      return left ? ((a << n) | (a >> (32 - n))) : ((a >> n) | (a << (32 - n)));
    if (left) return a << n;
    if (op == 2'b01) return $unsigned($signed(a) >>> n);
    return a >> n;
  endfunction

  function automatic bit modelOvf(logic [31:0] a, int n, bit left, logic [1:0] op);
    logic [31:0] r;
    bit o;
    if (!left || op == 2'b10) return 1'b0;
    r = a << n;
    o = 1'b0;
    for (int k = 32 - n; k < 32; k++) if (a[k] != r[31]) o = 1'b1;
    return o;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOne(logic [31:0] a, int n, bit left, logic [1:0] op);
    logic [31:0] er;
    string tag;
    @(negedge clk);
    opndIn = a; shiftAmt = 5'(n); goLeft = left; opSel = op;
    #1;
    er = modelRes(a, n, left, op);
    if (n == 0) tag = "R5";
    else if (op == 2'b11) tag = "R8";
    else if (op == 2'b10) tag = "R4";
    else if (left) tag = "R3";
    else if (op == 2'b01) tag = "R2";
    else tag = "R1";
    check({tag, " result"}, resultOut, er);
    check("R6 zero", {31'd0, zeroFlag}, {31'd0, er == 32'd0});
    check("R7 ovf", {31'd0, ovfFlag}, {31'd0, modelOvf(a, n, left, op)});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // idle state with zero inputs
    @(negedge clk);
    check("R6 idle result", resultOut, 32'd0);
    check("R6 idle zero", {31'd0, zeroFlag}, 32'd1);
    // R9: output follows input change in the same cycle, no edge
    @(posedge clk); #2;
    opndIn = 32'h8000_0001; shiftAmt = 5'd4; goLeft = 1'b0; opSel = 2'b10;
    #1;
    check("R9 immediate rotate", resultOut, 32'h1800_0000);
    // directed corners
    runOne(32'h4000_0000, 1, 1, 2'b00);   // R7 sets
    runOne(32'hC000_0000, 1, 1, 2'b01);   // R7 clear
    runOne(32'h8000_0000, 31, 0, 2'b01);  // R2 full fill
    runOne(32'hFFFF_FFFF, 31, 1, 2'b10);
    runOne(32'h0000_0001, 31, 1, 2'b00);
    runOne(32'h1234_5678, 0, 1, 2'b00);
    // exhaustive amounts, all selects and directions
    for (int op = 0; op < 4; op++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 32; n++) begin
          runOne(32'hA5C3_0F81, n, d[0], op[1:0]);
          runOne(32'h7FFF_FFFE, n, d[0], op[1:0]);
        end
    // R8: select 11 same outputs as select 00
    for (int n = 0; n < 32; n += 5) begin
      logic [31:0] r0, r3;
      @(negedge clk); opndIn = 32'hDEAD_BEEF; shiftAmt = 5'(n); goLeft = 1'b1; opSel = 2'b00;
      #1 r0 = resultOut;
      opSel = 2'b11;
      #1 r3 = resultOut;
      check("R8 spare equals logical", r3, r0);
    end
    // random
    for (int i = 0; i < 3000; i++)
      runOne($urandom, int'($urandom % 32), 1'($urandom), 2'($urandom));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule